// File: doc/BRIEF.md
# Frame-Synchronized Signalling Serial Port

This block is the serial front end for two low-rate signalling channels that travel inside a framed burst link. Each channel moves two bits per 125 µs frame (16 kbps). A frame strobe at 8 kHz marks frame boundaries and a separate data clock paces the serial bits. On the transmit side, bits arriving on each serial input are captured on data-clock falling edges into a two-bit holding register per channel. Each frame strobe hands that register, as a parallel word, to the modulator. On the receive side, each frame strobe latches a parallel word per channel from the demodulator. The block then plays those bits out on the serial outputs, starting at the strobe itself and stepping on data-clock rising edges.

The strobe and the data clock are asynchronous pins. Both are resynchronised into a faster core clock and turned into single-cycle edge pulses, so all state lives in one clock domain. The serial inputs pass through the same synchroniser depth, so each data bit stays aligned with the clock edge that samples it. Extra data-clock cycles inside a frame are harmless. On the input side they keep shifting, so the newest two bits win. On the output side they rotate the buffer, so the pins alternate between the two latched bits.

Top module: `dchan_serial_port`

## Requirements
- R1: While reset is high, and after it is released with idle inputs, `sout`, `mod_word` and `mod_load` are all zero.
- R2: Each data-clock falling edge shifts the current serial input bit of every channel into that channel's holding register. The older bit moves to the high position, so after two falls the first bit sits in the MSB of the channel field `[c*BITS +: BITS]`.
- R3: Falling edges beyond the second in a frame keep shifting, so the word handed over at the next strobe is the last two bits received, oldest in the MSB. The register is not cleared at the strobe.
- R4: On each frame-strobe rising edge the holding registers are copied to `mod_word` and `mod_load` pulses high for exactly one core cycle. `mod_word` holds its value between strobes.
- R5: A data-clock fall detected in the same core cycle as a strobe rise belongs to the new frame. The copied word excludes that bit, which is shifted in afterwards.
- R6: On each strobe rising edge, every `sout[c]` takes the MSB of that channel's field of `dem_word` at that edge, and the whole word is latched.
- R7: A data-clock rising edge that is not preceded by a falling edge since the last strobe leaves `sout` unchanged.
- R8: After a falling edge has been seen in the frame, the next data-clock rising edge puts the second latched bit (LSB of the field) on `sout[c]`.
- R9: Each further rising edge in the frame rotates the latched word, so `sout[c]` alternates MSB, LSB, MSB, and so on.
- R10: The strobe has priority. A data-clock fall in the strobe's own cycle does not count as a fall seen in the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the data clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_in | input | 1 | 8 kHz frame strobe, asynchronous |
| dclk_in | input | 1 | Serial data clock, asynchronous |
| sin | input | NCH | Serial inputs, one per channel |
| dem_word | input | NCH*BITS | Demodulated bits, channel c in [c*BITS +: BITS], first bit in MSB |
| mod_word | output | NCH*BITS | Word handed to the modulator, same layout |
| mod_load | output | 1 | One-cycle pulse when mod_word is updated |
| sout | output | NCH | Serial outputs, one per channel |

## Verification
The two actions that can collide are a frame-strobe rising edge and a data-clock falling edge. They arrive as pulses in the same core cycle, and that cycle both copies the holding register and shifts it, and both resets and arms the output sequencer. The bench provokes the collision by changing the strobe and the data-clock pins on the same instant, so both pass through equal synchroniser depth. It then judges three results: the handed-over word is the register before the colliding bit was shifted in, exactly one load pulse occurs, and the next rising edge leaves the output on the first bit rather than advancing it. A sweep over frame lengths, data-bit patterns and demodulated words covers the ordinary shift, hand-over and recirculation paths.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

    localparam int DEF_CHANNELS = 2;
    localparam int DEF_BITS     = 2;
    localparam int DEF_SYNC     = 2;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_kind_e;

    typedef struct packed {
        logic fs_rise;
        logic clk_rise;
        logic clk_fall;
    } strobe_t;

endpackage

// File: rtl/dchan_sync.sv
module dchan_sync #(
    parameter int SYNC = dchan_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl
);
    logic [SYNC-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[SYNC-2:0], din};
    end

    assign lvl = stg[SYNC-1];
endmodule

// File: rtl/dchan_edge.sv
module dchan_edge
    import dchan_pkg::*;
#(
    parameter edge_kind_e KIND = EDGE_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign pulse = lvl & ~prev;
        end else begin : g_fall
            assign pulse = ~lvl & prev;
        end
    endgenerate
endmodule

// File: rtl/dchan_rx_shift.sv
module dchan_rx_shift #(
    parameter int BITS = dchan_pkg::DEF_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            bit_in,
    input  logic            xfer_en,
    output logic [BITS-1:0] word
);
    logic [BITS-1:0] hold;

    // transfer reads the register before a same-cycle shift lands
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            word <= '0;
        end else begin
            if (shift_en) hold <= {hold[BITS-2:0], bit_in};
            if (xfer_en)  word <= hold;
        end
    end
endmodule

// File: rtl/dchan_tx_recirc.sv
module dchan_tx_recirc
    import dchan_pkg::*;
#(
    parameter int BITS = dchan_pkg::DEF_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  strobe_t         strb,
    input  logic [BITS-1:0] dem,
    output logic            bit_out
);
    logic [BITS-1:0] ring;
    logic            armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring    <= '0;
            armed   <= 1'b0;
            bit_out <= 1'b0;
        end else if (strb.fs_rise) begin
            ring    <= dem;
            armed   <= 1'b0;
            bit_out <= dem[BITS-1];
        end else begin
            if (strb.clk_fall) armed <= 1'b1;
            if (strb.clk_rise && armed) begin
                ring    <= {ring[BITS-2:0], ring[BITS-1]};
                bit_out <= ring[BITS-2];
            end
        end
    end
endmodule

// File: rtl/dchan_serial_port.sv
module dchan_serial_port
    import dchan_pkg::*;
#(
    parameter int NCH  = DEF_CHANNELS,
    parameter int BITS = DEF_BITS,
    parameter int SYNC = DEF_SYNC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fs_in,
    input  logic                dclk_in,
    input  logic [NCH-1:0]      sin,
    input  logic [NCH*BITS-1:0] dem_word,
    output logic [NCH*BITS-1:0] mod_word,
    output logic                mod_load,
    output logic [NCH-1:0]      sout
);
    localparam int WORDW = NCH * BITS;

    logic     fs_lvl;
    logic     dclk_lvl;
    logic [NCH-1:0] sin_lvl;
    strobe_t  strb;

    dchan_sync #(.SYNC(SYNC)) u_fs_sync (
        .clk(clk), .rst(rst), .din(fs_in), .lvl(fs_lvl)
    );
    dchan_sync #(.SYNC(SYNC)) u_dclk_sync (
        .clk(clk), .rst(rst), .din(dclk_in), .lvl(dclk_lvl)
    );

    dchan_edge #(.KIND(EDGE_RISE)) u_fs_rise (
        .clk(clk), .rst(rst), .lvl(fs_lvl), .pulse(strb.fs_rise)
    );
    dchan_edge #(.KIND(EDGE_RISE)) u_dclk_rise (
        .clk(clk), .rst(rst), .lvl(dclk_lvl), .pulse(strb.clk_rise)
    );
    dchan_edge #(.KIND(EDGE_FALL)) u_dclk_fall (
        .clk(clk), .rst(rst), .lvl(dclk_lvl), .pulse(strb.clk_fall)
    );

    logic [WORDW-1:0] mod_next;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            // data sees the same synchroniser depth as the data clock
            dchan_sync #(.SYNC(SYNC)) u_sin_sync (
                .clk(clk), .rst(rst), .din(sin[c]), .lvl(sin_lvl[c])
            );

            dchan_rx_shift #(.BITS(BITS)) u_rx (
                .clk      (clk),
                .rst      (rst),
                .shift_en (strb.clk_fall),
                .bit_in   (sin_lvl[c]),
                .xfer_en  (strb.fs_rise),
                .word     (mod_next[c*BITS +: BITS])
            );

            dchan_tx_recirc #(.BITS(BITS)) u_tx (
                .clk     (clk),
                .rst     (rst),
                .strb    (strb),
                .dem     (dem_word[c*BITS +: BITS]),
                .bit_out (sout[c])
            );
        end
    endgenerate

    assign mod_word = mod_next;

    always_ff @(posedge clk) begin
        if (rst) mod_load <= 1'b0;
        else     mod_load <= strb.fs_rise;
    end
endmodule

// File: rtl/dchan_serial_port_chk.sv
module dchan_serial_port_chk #(
    parameter int NCH  = 2,
    parameter int BITS = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                fs_rise,
    input logic                dclk_rise,
    input logic [NCH*BITS-1:0] dem_word,
    input logic [NCH*BITS-1:0] mod_word,
    input logic                mod_load,
    input logic [NCH-1:0]      sout
);
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mod_load |=> !mod_load); // R4

    AST_MOD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !fs_rise |=> $stable(mod_word)); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fs_rise && !dclk_rise) |=> $stable(sout)); // R7

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
                fs_rise |=> sout[c] == $past(dem_word[c*BITS + BITS - 1])); // R6
        end
    endgenerate
endmodule

bind dchan_serial_port dchan_serial_port_chk #(.NCH(NCH), .BITS(BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fs_rise   (strb.fs_rise),
    .dclk_rise (strb.clk_rise),
    .dem_word  (dem_word),
    .mod_word  (mod_word),
    .mod_load  (mod_load),
    .sout      (sout)
);

// File: tb/dchan_serial_port_test.sv
`timescale 1ns/1ps
module dchan_serial_port_test;
    localparam int NCH  = 2;
    localparam int BITS = 2;
    localparam int H    = 8;   // data-clock half period in core cycles

    logic       clk  = 1'b0;
    logic       rst  = 1'b1;
    logic       fs   = 1'b0;
    logic       dclk = 1'b0;
    logic [1:0] sin  = '0;
    logic [3:0] dem  = '0;
    logic [3:0] mod;
    logic       load;
    logic [1:0] sout;

    always #2.5 clk = ~clk;

    dchan_serial_port #(.NCH(NCH), .BITS(BITS)) uut (
        .clk(clk), .rst(rst), .fs_in(fs), .dclk_in(dclk), .sin(sin),
        .dem_word(dem), .mod_word(mod), .mod_load(load), .sout(sout)
    );

    int runs = 0, fails = 0, loads = 0, prev_falls = 0;
    bit done = 1'b0;
    logic [1:0] ebuf [0:1];

    always @(posedge clk) begin
        if (rst) loads <= 0;
        else if (load) loads <= loads + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [1:0] out_exp(input logic [3:0] d, input int k);
        logic [1:0] r;
        for (int c = 0; c < 2; c++) r[c] = d[c*2 + 1 - (k % 2)];
        return r;
    endfunction

    task automatic shift_model(input logic [1:0] b);
        for (int c = 0; c < 2; c++) ebuf[c] = {ebuf[c][0], b[c]};
        prev_falls++;
    endtask

    function automatic logic [3:0] mod_exp();
        return {ebuf[1], ebuf[0]};
    endfunction

    // strobe coincides with the first data-clock rise of the frame
    task automatic normal_frame(input int nrise, input logic [3:0] d, input int seed);
        logic [3:0] m;
        int l0;
        string tag;
        dem = d;
        wait_n(4);
        m   = mod_exp();
        l0  = loads;
        tag = (prev_falls > 2) ? "R3" : "R2";
        prev_falls = 0;
        for (int k = 0; k < nrise; k++) begin
            logic [1:0] b;
            b = 2'((seed + 3*k) & 3);
            dclk = 1'b1;
            sin  = b;
            if (k == 0) fs = 1'b1;
            wait_n(H-2);
            if (k == 0) begin
                chk("R6 first bit at strobe", 32'(sout), 32'(out_exp(d, 0)));
                chk({tag, " R4 handed-over word"}, 32'(mod), 32'(m));
                chk("R4 one load pulse", 32'(loads - l0), 32'd1);
            end else if (k == 1) begin
                chk("R8 second bit", 32'(sout), 32'(out_exp(d, 1)));
            end else begin
                chk("R9 recirculation", 32'(sout), 32'(out_exp(d, k)));
            end
            wait_n(2);
            dclk = 1'b0;
            fs   = 1'b0;
            shift_model(b);
            wait_n(H);
        end
    endtask

    // strobe lands on a data-clock fall
    task automatic skew_frame(input logic [3:0] d, input int seed);
        logic [3:0] m;
        int l0;
        logic [1:0] b [0:3];
        for (int i = 0; i < 4; i++) b[i] = 2'((seed + 5*i + 1) & 3);
        dem  = d;
        dclk = 1'b1;
        sin  = b[0];
        wait_n(H);
        m  = mod_exp();
        l0 = loads;
        prev_falls = 0;
        fs   = 1'b1;
        dclk = 1'b0;
        shift_model(b[0]);
        wait_n(H-2);
        chk("R6 first bit at strobe", 32'(sout), 32'(out_exp(d, 0)));
        chk("R5 colliding bit excluded", 32'(mod), 32'(m));
        chk("R5 one load pulse", 32'(loads - l0), 32'd1);
        wait_n(2);
        fs = 1'b0;
        for (int k = 1; k < 4; k++) begin
            dclk = 1'b1;
            sin  = b[k];
            wait_n(H-2);
            if (k == 1)      chk("R7 R10 rise holds first bit", 32'(sout), 32'(out_exp(d, 0)));
            else if (k == 2) chk("R8 second bit", 32'(sout), 32'(out_exp(d, 1)));
            else             chk("R9 recirculation", 32'(sout), 32'(out_exp(d, 0)));
            wait_n(2);
            dclk = 1'b0;
            shift_model(b[k]);
            wait_n(H);
        end
    endtask

    // strobe while the data clock is idle low
    task automatic late_frame(input logic [3:0] d, input int seed);
        logic [3:0] m;
        logic [1:0] b0, b1;
        b0 = 2'(seed & 3);
        b1 = 2'((seed >> 1) & 3);
        dem = d;
        wait_n(4);
        m = mod_exp();
        prev_falls = 0;
        fs = 1'b1;
        wait_n(H);
        chk("R4 handed-over word", 32'(mod), 32'(m));
        fs   = 1'b0;
        dclk = 1'b1;
        sin  = b0;
        wait_n(H-2);
        chk("R7 rise without fall", 32'(sout), 32'(out_exp(d, 0)));
        wait_n(2);
        dclk = 1'b0;
        shift_model(b0);
        wait_n(H);
        dclk = 1'b1;
        sin  = b1;
        wait_n(H-2);
        chk("R8 second bit", 32'(sout), 32'(out_exp(d, 1)));
        wait_n(2);
        dclk = 1'b0;
        shift_model(b1);
        wait_n(H);
    endtask

    initial begin
        ebuf[0] = '0;
        ebuf[1] = '0;
        wait_n(5);
        chk("R1 sout in reset", 32'(sout), 32'd0);
        chk("R1 mod_word in reset", 32'(mod), 32'd0);
        chk("R1 mod_load in reset", 32'(load), 32'd0);
        rst = 1'b0;
        wait_n(6);
        chk("R1 sout after reset", 32'(sout), 32'd0);
        chk("R1 mod_word after reset", 32'(mod), 32'd0);
        for (int n = 1; n <= 4; n++) begin
            for (int p = 0; p < 16; p++) begin
                normal_frame(n, 4'(p ^ (n*5)), p + n);
            end
        end
        for (int p = 0; p < 4; p++) begin
            skew_frame(4'(p*7 + 2), p);
            late_frame(4'(p*3 + 5), p + 2);
        end
        normal_frame(2, 4'h9, 1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            runs++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule